// File: doc/BRIEF.md
# Serial EEPROM Byte-Protocol Core

This block is the byte-level half of a serial EEPROM slave on a two-wire bus. A bit-level front end, outside this block, detects bus conditions and delivers them as events: a start addressed for writing (with the low bits of the slave address that matched), a start addressed for reading, a stop, a received byte, and a demand for a byte to send. The core keeps a word-address pointer and loads it from one or two address bytes. It stores written bytes into an internal synchronous RAM and returns read bytes from that RAM. It reports for every received byte whether the byte is acknowledged.

Writes advance the pointer inside the current page and wrap back to the page start. Reads advance it across the whole array and wrap from the last byte to byte zero. For small arrays the top word-address bits come from the slave address rather than from an address byte, so one device answers on a group of neighbouring slave addresses. The core publishes that address and the match mask as constant outputs for the front end.

Events enter on a valid/ready channel. A byte event (receive or send) produces exactly one beat on the response channel. The response is held until the front end takes it, and no new event is accepted until then. Start and stop events produce no response.

Top module: `ee_xact_core`

## Requirements
- R1: After reset the core is idle with a word address of zero, `ev_ready` is 1 and `rsp_valid` is 0; a start-read followed by a send demand then returns 0x00.
- R2: `slv_addr` equals 0x50 OR ((DEV_NUM masked to DEV_BITS bits) shifted left by HI_BITS), and `slv_mask` equals 0x7F with its low HI_BITS bits cleared.
- R3: A start-write accepted while idle replaces the word address with (ev_byte AND (2^HI_BITS-1)) shifted left by 16 when ADDR16=1, or by 8 when ADDR16=0. It then waits for a high address byte (ADDR16=1) or directly for the low address byte (ADDR16=0).
- R4: An address byte is ORed into the pointer after truncation to the array size: the high byte into bits 15:8, the low byte into bits 7:0. Both are acknowledged (`rsp_nack`=0), and after the low byte the core waits for the first data byte.
- R5: A data byte received after the address phase, with `wp` low, is written at the pointer and acknowledged. The pointer then steps within its page: the bits above the page offset are unchanged and the offset wraps from PAGE_BYTES-1 to 0.
- R6: With `wp` high a data byte is acknowledged and the pointer steps as in R5, but the stored byte at that location is unchanged.
- R7: In the read-data state each send demand returns the byte at the pointer, and the pointer then advances by one modulo MEM_BYTES.
- R8: A start-read accepted while waiting for the first data byte enters read-data (repeated start). A start-read accepted while idle enters read-address, where the next send demand returns the low 8 bits of the pointer and the core returns to idle.
- R9: A start event in any other state, and a stop in every state, return the core to idle without changing the pointer.
- R10: A received byte outside the address and write-data states is refused (`rsp_nack`=1), and a send demand outside read-address and read-data returns 0x00; both return the core to idle.
- R11: Event codes on `ev_kind` are 0 start-write, 1 start-read, 2 stop, 3 received byte, 4 send demand. Each accepted code 3 or 4 raises `rsp_valid` one cycle later. The response holds with stable data until `rsp_ready` is seen, and `ev_ready` is low meanwhile. Codes 0 to 2 raise no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp | input | 1 | Write protect, blocks RAM updates when high |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Core can take an event |
| ev_kind | input | 3 | Event code (see R11) |
| ev_byte | input | 8 | Slave low bits for start-write, data for received byte |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Front end takes the response |
| rsp_data | output | 8 | Byte to send on a send demand |
| rsp_nack | output | 1 | Received byte refused |
| slv_addr | output | 7 | Slave address to match |
| slv_mask | output | 7 | Bits of slave address that must match |

## Verification
The hardest situation to reach is a pointer at a page end while a write runs past it, and the same pointer at the last array byte while a read runs past it. Both need a full address phase to land exactly on the boundary first. The stimulus addresses pages at chosen offsets, including the top bit supplied through the slave address, and fills the whole array one page per transaction. It then reads the array end to end and through the wrap to zero. The bench then recovers the pointer through the read-address state, which exposes the page-local wrap from the ports.

// File: rtl/ee_xact_pkg.sv
package ee_xact_pkg;
  typedef enum logic [2:0] {
    EV_START_WR = 3'd0,
    EV_START_RD = 3'd1,
    EV_STOP     = 3'd2,
    EV_RX_BYTE  = 3'd3,
    EV_TX_REQ   = 3'd4
  } ev_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_WA_HI,
    ST_WA_LO,
    ST_DATA0,
    ST_RD_DATA,
    ST_WR_DATA
  } xact_state_e;
endpackage

// File: rtl/ee_id_gen.sv
module ee_id_gen #(
  parameter int HI_BITS  = 1,
  parameter int DEV_BITS = 2,
  parameter int DEV_NUM  = 1
) (
  output logic [6:0] slv_addr,
  output logic [6:0] slv_mask
);
  localparam int DEV_MASK = (1 << DEV_BITS) - 1;
  localparam int HI_MASK  = (1 << HI_BITS) - 1;
  localparam logic [6:0] ADDR_C = 7'(32'h50 | ((DEV_NUM & DEV_MASK) << HI_BITS));
  localparam logic [6:0] MASK_C = 7'(32'h7F & ~HI_MASK);

  assign slv_addr = ADDR_C;
  assign slv_mask = MASK_C;
endmodule

// File: rtl/ee_addr_step.sv
module ee_addr_step #(
  parameter int AW         = 9,
  parameter int PAGE_BYTES = 16
) (
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] page_next,
  output logic [AW-1:0] array_next
);
  localparam int OW = $clog2(PAGE_BYTES);

  assign array_next = cur + 1'b1;

  generate
    if (OW == 0) begin : g_single
      assign page_next = cur;
    end else if (OW >= AW) begin : g_whole
      assign page_next = cur + 1'b1;
    end else begin : g_page
      logic [OW-1:0] off_inc;
      assign off_inc   = cur[OW-1:0] + 1'b1;
      assign page_next = {cur[AW-1:OW], off_inc};
    end
  endgenerate
endmodule

// File: rtl/ee_sram.sv
module ee_sram #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ee_xact_core.sv
module ee_xact_core #(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16,
  parameter int HI_BITS    = 1,
  parameter bit ADDR16     = 1'b0,
  parameter int DEV_BITS   = 2,
  parameter int DEV_NUM    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp,
  input  logic       ev_valid,
  output logic       ev_ready,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       rsp_nack,
  output logic [6:0] slv_addr,
  output logic [6:0] slv_mask
);
  import ee_xact_pkg::*;

  localparam int AW       = $clog2(MEM_BYTES);
  localparam int HI_SHIFT = ADDR16 ? 16 : 8;
  localparam int HI_MASK  = (1 << HI_BITS) - 1;

  xact_state_e   st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] page_next, array_next;
  logic [AW-1:0] hi_part, hi_byte, lo_byte;
  logic [2:0]    hi_sel;
  logic          acc, we, re, rsp_set, nack_d, from_ram_d;
  logic [7:0]    byte_d, ram_q;
  logic          rsp_valid_q, rsp_nack_q, from_ram_q;
  logic [7:0]    rsp_byte_q;

  ee_id_gen #(.HI_BITS(HI_BITS), .DEV_BITS(DEV_BITS), .DEV_NUM(DEV_NUM)) u_id (
    .slv_addr(slv_addr),
    .slv_mask(slv_mask)
  );

  ee_addr_step #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_step (
    .cur(addr_q),
    .page_next(page_next),
    .array_next(array_next)
  );

  ee_sram #(.DEPTH(MEM_BYTES), .AW(AW)) u_ram (
    .clk(clk),
    .we(we),
    .waddr(addr_q),
    .wdata(ev_byte),
    .re(re),
    .raddr(addr_q),
    .rdata(ram_q)
  );

  assign acc     = ev_valid && ev_ready;
  assign hi_sel  = ev_byte[2:0] & 3'(HI_MASK);
  assign hi_part = AW'(24'(hi_sel) << HI_SHIFT);
  assign hi_byte = AW'({8'b0, ev_byte, 8'b0});
  assign lo_byte = AW'({16'b0, ev_byte});

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    we         = 1'b0;
    re         = 1'b0;
    rsp_set    = 1'b0;
    nack_d     = 1'b0;
    byte_d     = 8'h00;
    from_ram_d = 1'b0;
    if (acc) begin
      case (ev_kind)
        EV_START_WR: begin
          if (st_q == ST_IDLE) begin
            addr_d = hi_part;
            st_d   = ADDR16 ? ST_WA_HI : ST_WA_LO;
          end else begin
            st_d = ST_IDLE;
          end
        end
        EV_START_RD: begin
          case (st_q)
            ST_IDLE:  st_d = ST_RD_ADDR;
            ST_DATA0: st_d = ST_RD_DATA;
            default:  st_d = ST_IDLE;
          endcase
        end
        EV_STOP: st_d = ST_IDLE;
        EV_RX_BYTE: begin
          rsp_set = 1'b1;
          case (st_q)
            ST_WA_HI: begin
              addr_d = addr_q | hi_byte;
              st_d   = ST_WA_LO;
            end
            ST_WA_LO: begin
              addr_d = addr_q | lo_byte;
              st_d   = ST_DATA0;
            end
            ST_DATA0, ST_WR_DATA: begin
              we     = !wp;
              addr_d = page_next;
              st_d   = ST_WR_DATA;
            end
            default: begin
              nack_d = 1'b1;
              st_d   = ST_IDLE;
            end
          endcase
        end
        EV_TX_REQ: begin
          rsp_set = 1'b1;
          case (st_q)
            ST_RD_ADDR: begin
              byte_d = 8'(addr_q);
              st_d   = ST_IDLE;
            end
            ST_RD_DATA: begin
              re         = 1'b1;
              from_ram_d = 1'b1;
              addr_d     = array_next;
            end
            default: st_d = ST_IDLE;
          endcase
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_nack_q  <= 1'b0;
      rsp_byte_q  <= 8'h00;
      from_ram_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      if (rsp_set) begin
        rsp_valid_q <= 1'b1;
        rsp_nack_q  <= nack_d;
        rsp_byte_q  <= byte_d;
        from_ram_q  <= from_ram_d;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign ev_ready  = !rsp_valid_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_nack  = rsp_nack_q;
  assign rsp_data  = from_ram_q ? ram_q : rsp_byte_q;
endmodule

// File: rtl/ee_xact_core_chk.sv
module ee_xact_core_chk #(
  parameter int AW         = 9,
  parameter int PAGE_BYTES = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ev_valid,
  input logic                     ev_ready,
  input logic [2:0]               ev_kind,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [7:0]               rsp_data,
  input logic                     rsp_nack,
  input ee_xact_pkg::xact_state_e st,
  input logic [AW-1:0]            addr
);
  import ee_xact_pkg::*;
  localparam int OW = $clog2(PAGE_BYTES);

  logic acc;
  assign acc = ev_valid && ev_ready;

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (ev_kind == EV_RX_BYTE || ev_kind == EV_TX_REQ) |=> rsp_valid);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_nack));

  assert_ctrl_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (ev_kind == EV_START_WR || ev_kind == EV_START_RD || ev_kind == EV_STOP)
    |=> !rsp_valid);

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ev_kind == EV_STOP |=> st == ST_IDLE);

  assert_idle_rx_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ev_kind == EV_RX_BYTE && st == ST_IDLE |=> rsp_nack && st == ST_IDLE);

  assert_rd_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ev_kind == EV_TX_REQ && st == ST_RD_DATA |=> addr == AW'($past(addr) + 1));

  generate
    if (OW > 0 && OW < AW) begin : g_page_chk
      assert_page_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && ev_kind == EV_RX_BYTE && (st == ST_DATA0 || st == ST_WR_DATA)
        |=> addr[AW-1:OW] == $past(addr[AW-1:OW]));
    end
  endgenerate
endmodule

bind ee_xact_core ee_xact_core_chk #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ev_valid(ev_valid),
  .ev_ready(ev_ready),
  .ev_kind(ev_kind),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data(rsp_data),
  .rsp_nack(rsp_nack),
  .st(st_q),
  .addr(addr_q)
);

// File: tb/ee_xact_core_tb.sv
module ee_xact_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0;
  logic ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'h00;
  logic rsp_ready = 1'b0;
  logic sel16 = 1'b0;

  logic er8, rv8, rn8, er16, rv16, rn16;
  logic [7:0] rd8, rd16;
  logic [6:0] sa8, sm8, sa16, sm16;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] got_d;
  logic got_n, got_v;
  logic [7:0] m8 [512];
  logic [7:0] m16 [1024];
  int last_addr;

  always #10 clk = ~clk;

  ee_xact_core #(.MEM_BYTES(512), .PAGE_BYTES(16), .HI_BITS(1), .ADDR16(1'b0),
                 .DEV_BITS(2), .DEV_NUM(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp(wp),
    .ev_valid(ev_valid && !sel16), .ev_ready(er8), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .rsp_valid(rv8), .rsp_ready(rsp_ready && !sel16), .rsp_data(rd8), .rsp_nack(rn8),
    .slv_addr(sa8), .slv_mask(sm8)
  );

  ee_xact_core #(.MEM_BYTES(1024), .PAGE_BYTES(32), .HI_BITS(0), .ADDR16(1'b1),
                 .DEV_BITS(3), .DEV_NUM(5)) u_dut16 (
    .clk(clk), .rst_n(rst_n), .wp(wp),
    .ev_valid(ev_valid && sel16), .ev_ready(er16), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .rsp_valid(rv16), .rsp_ready(rsp_ready && sel16), .rsp_data(rd16), .rsp_nack(rn16),
    .slv_addr(sa16), .slv_mask(sm16)
  );

  wire       ev_ready_m  = sel16 ? er16 : er8;
  wire       rsp_valid_m = sel16 ? rv16 : rv8;
  wire [7:0] rsp_data_m  = sel16 ? rd16 : rd8;
  wire       rsp_nack_m  = sel16 ? rn16 : rn8;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int msize();
    return sel16 ? 1024 : 512;
  endfunction

  function automatic int pnext(input int a);
    int pg = sel16 ? 32 : 16;
    return (a & ~(pg - 1)) | ((a + 1) & (pg - 1));
  endfunction

  task automatic do_ev(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
    if (k == 3'd3 || k == 3'd4) begin
      got_v = rsp_valid_m; got_d = rsp_data_m; got_n = rsp_nack_m;
      chk("R11 response present", 32'(got_v), 32'd1);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end
  endtask

  // Address phase; garbage in unused slave/high bits tests masking (R3, R4)
  task automatic set_addr(input int a0);
    if (!sel16) begin
      do_ev(3'd0, 8'(32'h06 | ((a0 >> 8) & 1)));
      do_ev(3'd3, 8'(a0));
      chk("R4 low address ack", 32'(got_n), 32'd0);
    end else begin
      do_ev(3'd0, 8'h07);
      do_ev(3'd3, 8'(32'hFC | ((a0 >> 8) & 3)));
      chk("R4 high address ack", 32'(got_n), 32'd0);
      do_ev(3'd3, 8'(a0));
      chk("R4 low address ack", 32'(got_n), 32'd0);
    end
  endtask

  task automatic wr_run(input int a0, input int n, input int seed);
    int a = a0;
    set_addr(a0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'(a * 13 + seed + i);
      do_ev(3'd3, d);
      chk(wp ? "R6 protected data ack" : "R5 data ack", 32'(got_n), 32'd0);
      if (!wp) begin
        if (sel16) m16[a] = d; else m8[a] = d;
      end
      a = pnext(a);
    end
    do_ev(3'd2, 8'h00);
    last_addr = a;
  endtask

  task automatic rd_run(input int a0, input int n);
    int a = a0;
    set_addr(a0);
    do_ev(3'd1, 8'h00);
    for (int i = 0; i < n; i++) begin
      do_ev(3'd4, 8'h00);
      chk("R7 read data", 32'(got_d), 32'(sel16 ? m16[a] : m8[a]));
      a = (a + 1) % msize();
    end
    do_ev(3'd2, 8'h00);
    last_addr = a;
  endtask

  task automatic rd_ptr(input int exp);
    do_ev(3'd1, 8'h00);
    do_ev(3'd4, 8'h00);
    chk("R8 read-address returns pointer", 32'(got_d), 32'(exp & 255));
    do_ev(3'd4, 8'h00);
    chk("R10 send demand when idle", 32'(got_d), 32'h00);
    do_ev(3'd2, 8'h00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [7:0] d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ev_ready", 32'(er8), 32'd1);
    chk("R1 rsp_valid", 32'(rv8), 32'd0);
    chk("R1 ev_ready wide", 32'(er16), 32'd1);
    // R2 identity
    chk("R2 slave address", 32'(sa8), 32'h52);
    chk("R2 slave mask", 32'(sm8), 32'h7E);
    chk("R2 slave address wide", 32'(sa16), 32'h55);
    chk("R2 slave mask wide", 32'(sm16), 32'h7F);
    // R1 pointer zero after reset
    do_ev(3'd1, 8'h00);
    do_ev(3'd4, 8'h00);
    chk("R1 pointer after reset", 32'(got_d), 32'h00);
    do_ev(3'd2, 8'h00);
    // R10 received byte in idle
    do_ev(3'd3, 8'h5A);
    chk("R10 idle byte refused", 32'(got_n), 32'd1);

    // R5/R7 full sweep of 1-byte addressed array, R3 top bit via slave address
    for (int p = 0; p < 32; p++) wr_run(p * 16, 16, 5);
    rd_run(0, 512);
    rd_run(32'h1FC, 8);
    rd_ptr(last_addr);

    // R5 page wrap on writes
    wr_run(32'h0AC, 6, 9);
    rd_run(32'h0A0, 16);
    wr_run(32'h130, 20, 21);
    rd_run(32'h130, 16);
    wr_run(32'h0AE, 3, 33);
    rd_ptr(32'h0A1);
    wr_run(32'h1FE, 3, 41);
    rd_ptr(32'hF1);

    // R6 write protect
    wp = 1'b1;
    wr_run(32'h040, 5, 77);
    rd_ptr(32'h45);
    wp = 1'b0;
    rd_run(32'h040, 8);

    // R10 byte refused in read-data and read-address
    set_addr(32'h010);
    do_ev(3'd1, 8'h00);
    do_ev(3'd3, 8'h11);
    chk("R10 byte in read-data refused", 32'(got_n), 32'd1);
    do_ev(3'd4, 8'h00);
    chk("R10 send after refusal is zero", 32'(got_d), 32'h00);
    do_ev(3'd2, 8'h00);
    do_ev(3'd1, 8'h00);
    do_ev(3'd3, 8'h22);
    chk("R10 byte in read-address refused", 32'(got_n), 32'd1);
    do_ev(3'd2, 8'h00);

    // R9 start in other states, stop in data wait
    do_ev(3'd0, 8'h00);
    do_ev(3'd0, 8'h00);
    do_ev(3'd3, 8'h33);
    chk("R9 start-write in address phase goes idle", 32'(got_n), 32'd1);
    wr_run(32'h077, 1, 3);
    set_addr(32'h066);
    do_ev(3'd3, 8'h44);
    m8[32'h066] = 8'h44;
    do_ev(3'd1, 8'h00);
    do_ev(3'd4, 8'h00);
    chk("R9 start-read in write-data goes idle", 32'(got_d), 32'h00);
    do_ev(3'd2, 8'h00);
    set_addr(32'h055);
    do_ev(3'd2, 8'h00);
    do_ev(3'd3, 8'h55);
    chk("R9 stop in first-data goes idle", 32'(got_n), 32'd1);
    rd_run(32'h066, 1);

    // R11 back-pressure on the response
    set_addr(32'h010);
    do_ev(3'd1, 8'h00);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 3'd4;
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R11 response raised", 32'(rv8), 32'd1);
    chk("R11 event blocked", 32'(er8), 32'd0);
    d0 = rd8;
    chk("R7 held read data", 32'(d0), 32'(m8[32'h010]));
    repeat (3) @(negedge clk);
    chk("R11 response held", 32'(rv8), 32'd1);
    chk("R11 data stable", 32'(rd8), 32'(d0));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R11 response released", 32'(rv8), 32'd0);
    chk("R11 event ready again", 32'(er8), 32'd1);
    do_ev(3'd2, 8'h00);
    chk("R11 stop has no response", 32'(rv8), 32'd0);

    // 2-byte addressed array: R3/R4 high byte masked, R5/R7 sweep
    sel16 = 1'b1;
    for (int p = 0; p < 32; p++) wr_run(p * 32, 32, 11);
    rd_run(0, 1024);
    rd_run(32'h3FE, 6);
    wr_run(32'h310, 2, 99);
    rd_ptr(32'h12);
    rd_run(32'h30E, 6);
    wr_run(32'h21C, 8, 61);
    rd_run(32'h200, 32);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule